// File: doc/BRIEF.md
# Priority-resolved pin function multiplexer

This block decides which internal signal drives each of eight shared pads. Software programs a bank of 32-bit mux-control words through a simple word-wide write/read port. A read-only strap word is captured from the strap inputs while reset is held. For every pin, combinational logic evaluates an enable condition for each priority level. Each condition is an OR of AND-terms, and each term compares a right-aligned, masked field of some control or strap word against a value. The lowest-numbered level whose condition is true wins. The last level of each pin is the fallback and is always true.

The winning level, given as a 3-bit level number per pin, routes that level's peripheral output and output enable onto the pad. When the winning level is the pin's GPIO slot, the GPIO output and GPIO direction drive the pad instead. Pad input goes back only to the winning peripheral slot, or to the GPIO input. The GPIO slot is usually the fallback, but on one pin it is the highest-priority level and the fallback is a peripheral.

Top module: `pin_prio_mux`

## Requirements
- R1: While reset is low on a clock edge, every control word is cleared and the strap word captures `strapIn`. After reset is released, the strap word keeps that value even when `strapIn` changes.
- R2: The bus has seven mapped words: writable words at byte offsets 0x3C, 0x80, 0x84, 0x90, 0xA0 and 0xA4, and the read-only strap word at 0x70. A write at a mapped writable offset is seen on `busRdata` at the next read. Writes to 0x70 are ignored. An offset that is unmapped, misaligned (low two bits not zero) or above 0xFF reads zero, and writing to it changes no word.
- R3: The level number on `levelSel[3p+2:3p]` is the lowest level whose condition is true. The last level of each pin is always true. Pin 0 has levels 0 and 1 (GPIO at level 1): level 0 needs 0x80 bit 0 = 1. Pin 1 has three levels (GPIO at level 2): level 0 needs 0x90 bit 22 = 1, and level 1 needs 0x80 bit 4 = 1.
- R4: Pin 3, with GPIO at level 2. Level 0 needs 0x3C bit 3 = 1, 0x80 bit 15 = 1 and 0x90 bit 31 = 0. Level 1 needs the same first two bits with 0x90 bit 31 = 1.
- R5: Pin 4, with GPIO at level 2. Level 0 needs the mode field 0x90[5:4] to be 1, 2 or 3, and 0x84 bit 17 = 1. Level 1 needs only 0x84 bit 17 = 1, so it wins when the mode is 0.
- R6: Pin 5, with GPIO at level 2. Level 0 needs 0x90[5:4] = 3 and 0x84 bit 22 = 1. Level 1 needs only 0x84 bit 22 = 1.
- R7: Pin 2, with GPIO at level 2. Level 0 needs 0x80 bit 25 = 1. Level 1 needs 0xA4 bit 12 = 1 OR strap bit 19 = 0.
- R8: Pin 6 has GPIO at level 0, enabled by 0xA0 bit 0 = 1. Level 1 is a peripheral enabled by strap bit 6 = 0. Level 2 is a peripheral fallback.
- R9: Pin 7 has five levels, with GPIO at level 4. Level k (k = 0..3) needs 0xA4 bit k = 1.
- R10: `padOut[p]` and `padOe[p]` follow `perOut[5p+l]` and `perOe[5p+l]` of the winning level l. When l is the pin's GPIO slot, they follow `gpioOut[p]` and `gpioOe[p]`.
- R11: `perIn[5p+l]` equals `padIn[p]` only for the winning non-GPIO level l, and is 0 for every other slot. `gpioIn[p]` equals `padIn[p]` only when the GPIO slot wins, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; captures straps |
| strapIn | input | 32 | Strap inputs sampled during reset |
| busWe | input | 1 | Write strobe |
| busAddr | input | ADDR_W | Byte address of the word accessed |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| perOut | input | 40 | Peripheral output, slot 5*pin+level |
| perOe | input | 40 | Peripheral output enable, slot 5*pin+level |
| perIn | output | 40 | Pad input steered to the winning peripheral slot |
| gpioOut | input | 8 | GPIO output per pin |
| gpioOe | input | 8 | GPIO direction per pin |
| gpioIn | output | 8 | Pad input steered to GPIO |
| padIn | input | 8 | Pad input values |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| levelSel | output | 24 | Winning level number, 3 bits per pin |

## Verification
The bench builds the block with ADDR_W = 10 instead of the default of 8. This places offsets such as 0x180 within reach, so the bench can show that a write above 0xFF does not alias onto the word at 0x80. The bench resets the block twice with different strap values, which exercises both polarities of the strap-qualified terms on pins 2 and 6. Between control writes it rotates the peripheral, GPIO and pad patterns, so routing and input steering are compared on every pin after every change.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int NPINS = 8;
  localparam int NLVL  = 5;
  localparam int LVL_W = $clog2(NLVL);
  localparam int REG_W = 32;
  localparam int NCTL  = 6;

  typedef struct packed {
    logic [REG_W-1:0] rst3c;
    logic [REG_W-1:0] ctl80;
    logic [REG_W-1:0] ctl84;
    logic [REG_W-1:0] ctl90;
    logic [REG_W-1:0] ctlA0;
    logic [REG_W-1:0] ctlA4;
    logic [REG_W-1:0] strap;
  } muxCfg_t;

  function automatic int gpioLevel(input int p);
    case (p)
      0: return 1;
      6: return 0;
      7: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic int lastLevel(input int p);
    case (p)
      0: return 1;
      7: return 4;
      default: return 2;
    endcase
  endfunction

  // masked, right-aligned field compare
  function automatic logic fieldEq(input logic [REG_W-1:0] r, input int lsb,
                                   input int w, input logic [REG_W-1:0] en);
    logic [REG_W-1:0] m;
    m = (REG_W'(1) << w) - REG_W'(1);
    return ((r >> lsb) & m) == en;
  endfunction

  function automatic logic [NLVL-1:0] levelTerms(input int p, input muxCfg_t c);
    logic [NLVL-1:0] t;
    logic both;
    t = '0;
    both = fieldEq(c.rst3c, 3, 1, 1) & fieldEq(c.ctl80, 15, 1, 1);
    case (p)
      0: t[0] = fieldEq(c.ctl80, 0, 1, 1);
      1: begin
        t[0] = fieldEq(c.ctl90, 22, 1, 1);
        t[1] = fieldEq(c.ctl80, 4, 1, 1);
      end
      2: begin
        t[0] = fieldEq(c.ctl80, 25, 1, 1);
        t[1] = fieldEq(c.ctlA4, 12, 1, 1) | fieldEq(c.strap, 19, 1, 0);
      end
      3: begin
        t[0] = both & fieldEq(c.ctl90, 31, 1, 0);
        t[1] = both & fieldEq(c.ctl90, 31, 1, 1);
      end
      4: begin
        t[0] = (fieldEq(c.ctl90, 4, 2, 1) & fieldEq(c.ctl84, 17, 1, 1))
             | (fieldEq(c.ctl90, 4, 2, 2) & fieldEq(c.ctl84, 17, 1, 1))
             | (fieldEq(c.ctl90, 4, 2, 3) & fieldEq(c.ctl84, 17, 1, 1));
        t[1] = fieldEq(c.ctl84, 17, 1, 1);
      end
      5: begin
        t[0] = fieldEq(c.ctl90, 4, 2, 3) & fieldEq(c.ctl84, 22, 1, 1);
        t[1] = fieldEq(c.ctl84, 22, 1, 1);
      end
      6: begin
        t[0] = fieldEq(c.ctlA0, 0, 1, 1);
        t[1] = fieldEq(c.strap, 6, 1, 0);
      end
      default: begin
        for (int k = 0; k < 4; k++) t[k] = fieldEq(c.ctlA4, k, 1, 1);
      end
    endcase
    t[lastLevel(p)] = 1'b1;
    return t;
  endfunction
endpackage

// File: rtl/pmx_ctrl.sv
module pmx_ctrl
  import pmx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  strapIn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  output muxCfg_t           cfg
);
  localparam logic [7:0] CTL_OFF [NCTL] = '{8'h3C, 8'h80, 8'h84, 8'h90, 8'hA0, 8'hA4};
  localparam logic [ADDR_W-1:0] STRAP_A = ADDR_W'(8'h70);

  logic [NCTL-1:0][REG_W-1:0] ctlQ;
  logic [REG_W-1:0]           strapQ;
  logic [NCTL-1:0]            hit;
  logic                       strapHit;

  assign strapHit = (busAddr == STRAP_A);

  for (genvar i = 0; i < NCTL; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] OFF_A = ADDR_W'(CTL_OFF[i]);
    assign hit[i] = (busAddr == OFF_A);
    always_ff @(posedge clk) begin
      if (!rst_n)             ctlQ[i] <= '0;
      else if (busWe && hit[i]) ctlQ[i] <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strapQ <= strapIn;
  end

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NCTL; i++) if (hit[i]) busRdata = ctlQ[i];
    if (strapHit) busRdata = strapQ;
  end

  assign cfg = '{rst3c: ctlQ[0], ctl80: ctlQ[1], ctl84: ctlQ[2], ctl90: ctlQ[3],
                 ctlA0: ctlQ[4], ctlA4: ctlQ[5], strap: strapQ};

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(strapQ));
  // R2
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && (hit == '0)) |=> $stable(ctlQ));
endmodule

// File: rtl/pmx_route.sv
module pmx_route
  import pmx_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  muxCfg_t                  cfg,
  input  logic [NPINS*NLVL-1:0]    perOut,
  input  logic [NPINS*NLVL-1:0]    perOe,
  output logic [NPINS*NLVL-1:0]    perIn,
  input  logic [NPINS-1:0]         gpioOut,
  input  logic [NPINS-1:0]         gpioOe,
  output logic [NPINS-1:0]         gpioIn,
  input  logic [NPINS-1:0]         padIn,
  output logic [NPINS-1:0]         padOut,
  output logic [NPINS-1:0]         padOe,
  output logic [NPINS*LVL_W-1:0]   levelSel
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int GL = gpioLevel(p);
    localparam int LL = lastLevel(p);
    localparam logic [NLVL-1:0] ABOVE = NLVL'((1 << LL) - 1);

    logic [NLVL-1:0]  termV, winV, inV;
    logic [LVL_W-1:0] selV;
    logic             outV, oeV;

    always_comb begin
      termV = levelTerms(p, cfg);
      winV  = '0;
      selV  = '0;
      for (int l = NLVL - 1; l >= 0; l--) begin
        if (termV[l]) begin
          winV    = '0;
          winV[l] = 1'b1;
          selV    = LVL_W'(l);
        end
      end
    end

    always_comb begin
      outV = 1'b0;
      oeV  = 1'b0;
      inV  = '0;
      for (int l = 0; l < NLVL; l++) begin
        if (winV[l]) begin
          if (l == GL) begin
            outV = gpioOut[p];
            oeV  = gpioOe[p];
          end else begin
            outV   = perOut[p*NLVL+l];
            oeV    = perOe[p*NLVL+l];
            inV[l] = padIn[p];
          end
        end
      end
    end

    assign padOut[p]                   = outV;
    assign padOe[p]                    = oeV;
    assign perIn[p*NLVL +: NLVL]       = inV;
    assign gpioIn[p]                   = padIn[p] & winV[GL];
    assign levelSel[p*LVL_W +: LVL_W]  = selV;

    // R3
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(winV) == 1);
    // R3
    fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((termV & ABOVE) == '0) |-> (levelSel[p*LVL_W +: LVL_W] == LVL_W'(LL)));
    // R10
    gpio_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (levelSel[p*LVL_W +: LVL_W] == LVL_W'(GL)) |-> (padOe[p] == gpioOe[p]));
    // R11
    steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (levelSel[p*LVL_W +: LVL_W] != LVL_W'(GL)) |-> (gpioIn[p] == 1'b0));
  end
endmodule

// File: rtl/pin_prio_mux.sv
module pin_prio_mux
  import pmx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [REG_W-1:0]         strapIn,
  input  logic                     busWe,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [REG_W-1:0]         busWdata,
  output logic [REG_W-1:0]         busRdata,
  input  logic [NPINS*NLVL-1:0]    perOut,
  input  logic [NPINS*NLVL-1:0]    perOe,
  output logic [NPINS*NLVL-1:0]    perIn,
  input  logic [NPINS-1:0]         gpioOut,
  input  logic [NPINS-1:0]         gpioOe,
  output logic [NPINS-1:0]         gpioIn,
  input  logic [NPINS-1:0]         padIn,
  output logic [NPINS-1:0]         padOut,
  output logic [NPINS-1:0]         padOe,
  output logic [NPINS*LVL_W-1:0]   levelSel
);
  muxCfg_t cfg;

  pmx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strapIn(strapIn), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .cfg(cfg)
  );

  pmx_route u_route (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .perOut(perOut), .perOe(perOe),
    .perIn(perIn), .gpioOut(gpioOut), .gpioOe(gpioOe), .gpioIn(gpioIn),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .levelSel(levelSel)
  );
endmodule

// File: tb/pin_prio_mux_bench.sv
module pin_prio_mux_bench;
  localparam int AW = 10;

  typedef struct {
    int    kind;
    int    pin;
    logic [7:0] exp;
    string req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] strapIn = '0;
  logic        busWe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [39:0] perOut = '0, perOe = '0, perIn;
  logic [7:0]  gpioOut = '0, gpioOe = '0, gpioIn, padIn = '0, padOut, padOe;
  logic [23:0] levelSel;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t sbq[$];

  logic [31:0] sh3c, sh80, sh84, sh90, shA0, shA4, shStrap;

  always #2.5 clk = ~clk;

  pin_prio_mux #(.ADDR_W(AW)) u_pin_prio_mux (
    .clk(clk), .rst_n(rst_n), .strapIn(strapIn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .perOut(perOut), .perOe(perOe),
    .perIn(perIn), .gpioOut(gpioOut), .gpioOe(gpioOe), .gpioIn(gpioIn),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .levelSel(levelSel)
  );

  function automatic int bGl(int p);
    return (p == 0) ? 1 : (p == 6) ? 0 : (p == 7) ? 4 : 2;
  endfunction

  function automatic string selReq(int p);
    case (p)
      2: return "R7";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R8";
      7: return "R9";
      default: return "R3";
    endcase
  endfunction

  function automatic int refLevel(int p);
    logic a;
    a = sh3c[3] & sh80[15];
    case (p)
      0: return sh80[0] ? 0 : 1;
      1: return sh90[22] ? 0 : sh80[4] ? 1 : 2;
      2: return sh80[25] ? 0 : (shA4[12] | !shStrap[19]) ? 1 : 2;
      3: return (a & !sh90[31]) ? 0 : (a & sh90[31]) ? 1 : 2;
      4: return (sh90[5:4] != 2'd0 && sh84[17]) ? 0 : sh84[17] ? 1 : 2;
      5: return (sh90[5:4] == 2'd3 && sh84[22]) ? 0 : sh84[22] ? 1 : 2;
      6: return shA0[0] ? 0 : !shStrap[6] ? 1 : 2;
      default: return shA4[0] ? 0 : shA4[1] ? 1 : shA4[2] ? 2 : shA4[3] ? 3 : 4;
    endcase
  endfunction

  task automatic fail(string req, string what, logic [31:0] act, logic [31:0] exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  // monitor: pops expectations and compares against live outputs
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sbq.pop_front();
        case (it.kind)
          0: act = 8'(levelSel[it.pin*3 +: 3]);
          1: act = 8'(padOut[it.pin]);
          2: act = 8'(padOe[it.pin]);
          3: act = 8'(gpioIn[it.pin]);
          default: act = 8'(perIn[it.pin*5 +: 5]);
        endcase
        checks++;
        if (act !== it.exp)
          fail(it.req, $sformatf("pin%0d kind%0d", it.pin, it.kind), 32'(act), 32'(it.exp));
      end
    end
  end

  // driver side: push expected results for every pin
  task automatic pushAll();
    for (int p = 0; p < 8; p++) begin
      int lv;
      bit g;
      logic [4:0] pin5;
      item_t it;
      lv = refLevel(p);
      g = (lv == bGl(p));
      it.pin = p;
      it.kind = 0; it.exp = 8'(lv); it.req = selReq(p); sbq.push_back(it);
      it.kind = 1; it.exp = 8'(g ? gpioOut[p] : perOut[p*5+lv]); it.req = "R10"; sbq.push_back(it);
      it.kind = 2; it.exp = 8'(g ? gpioOe[p] : perOe[p*5+lv]); it.req = "R10"; sbq.push_back(it);
      it.kind = 3; it.exp = 8'(g ? padIn[p] : 1'b0); it.req = "R11"; sbq.push_back(it);
      pin5 = '0;
      if (!g) pin5[lv] = padIn[p];
      it.kind = 4; it.exp = 8'(pin5); it.req = "R11"; sbq.push_back(it);
    end
    wait (sbq.size() == 0);
    @(posedge clk);
    #1;
  endtask

  task automatic setStim(int k);
    logic [39:0] base;
    base = 40'hC3_A5_5A_3C_96;
    perOut = (base << (k % 7)) | (base >> (40 - (k % 7)));
    perOe  = ~perOut ^ 40'h0F_0F_0F_0F_0F;
    gpioOut = 8'h5A ^ 8'(k);
    gpioOe  = ~gpioOut ^ 8'h33;
    padIn   = 8'hC6 ^ 8'(k * 3);
  endtask

  task automatic doReset(logic [31:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    strapIn = s;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    strapIn = ~s;
    {sh3c, sh80, sh84, sh90, shA0, shA4} = '0;
    shStrap = s;
  endtask

  task automatic writeReg(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1;
    busAddr = a;
    busWdata = d;
    @(posedge clk);
    #1;
    busWe = 1'b0;
    case (a)
      10'h03C: sh3c = d;
      10'h080: sh80 = d;
      10'h084: sh84 = d;
      10'h090: sh90 = d;
      10'h0A0: shA0 = d;
      10'h0A4: shA4 = d;
      default: ;
    endcase
  endtask

  task automatic readChk(logic [AW-1:0] a, logic [31:0] exp, string req);
    busAddr = a;
    #1;
    checks++;
    if (busRdata !== exp) fail(req, $sformatf("read %0h", a), busRdata, exp);
  endtask

  task automatic step(logic [AW-1:0] a, logic [31:0] d, int k);
    writeReg(a, d);
    setStim(k);
    pushAll();
  endtask

  initial begin
    // first reset: strap bits 19 and 6 low
    doReset(32'h0000_1234);
    // R1: control words clear, strap captured and held
    readChk(10'h080, 32'h0, "R1");
    readChk(10'h0A4, 32'h0, "R1");
    readChk(10'h070, 32'h0000_1234, "R1");
    setStim(0);
    pushAll();

    step(10'h03C, 32'h0000_0008, 1);
    step(10'h080, 32'h0000_8011, 2);          // R3 pin0/1, R4 level 0
    step(10'h090, 32'h8040_0010, 3);          // R4 level 1, R3 pin1 level 0, mode 1
    step(10'h084, 32'h0042_0000, 4);          // R5 level 0, R6 level 1
    step(10'h090, 32'h8040_0030, 5);          // R6 mode 3 -> level 0
    step(10'h090, 32'h0000_0000, 6);          // R5/R6 mode 0 -> level 1, R4 back to 0
    step(10'h0A4, 32'h0000_000A, 7);          // R9 level 1
    step(10'h0A4, 32'h0000_0008, 8);          // R9 level 3
    step(10'h0A4, 32'h0000_0000, 9);          // R9 fallback 4
    step(10'h0A4, 32'h0000_000F, 10);         // R9 level 0
    step(10'h0A0, 32'h0000_0001, 11);         // R8 GPIO at level 0
    step(10'h080, 32'h0200_8011, 12);         // R7 level 0
    step(10'h03C, 32'h0000_0000, 13);         // R4 fallback

    // R2: readback, strap read-only, unmapped and misaligned offsets
    readChk(10'h080, 32'h0200_8011, "R2");
    readChk(10'h0A0, 32'h0000_0001, "R2");
    writeReg(10'h070, 32'hFFFF_FFFF);
    readChk(10'h070, 32'h0000_1234, "R2");
    writeReg(10'h180, 32'hDEAD_BEEF);
    readChk(10'h180, 32'h0, "R2");
    readChk(10'h080, 32'h0200_8011, "R2");
    writeReg(10'h081, 32'h1111_1111);
    readChk(10'h081, 32'h0, "R2");
    readChk(10'h080, 32'h0200_8011, "R2");
    writeReg(10'h040, 32'h2222_2222);
    readChk(10'h040, 32'h0, "R2");
    setStim(14);
    pushAll();

    // second reset: strap bits 19 and 6 high
    doReset(32'hA5A8_0040);
    readChk(10'h070, 32'hA5A8_0040, "R1");
    readChk(10'h090, 32'h0, "R1");
    setStim(15);
    pushAll();                                // R7 fallback, R8 peripheral fallback
    step(10'h0A4, 32'h0000_1000, 16);         // R7 via control bit
    step(10'h0A0, 32'h0000_0001, 17);         // R8 GPIO wins again

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule